// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps the coherence state of a write-back cache attached to a shared snooping bus. It tracks a small, parameterised number of lines. Each line carries a tag and one of three states: Invalid, Shared (memory holds the same data, and other caches may hold copies) and Modified (dirty, and the only valid copy). The data array, the bus arbiter and memory all sit outside the block.

The processor presents requests on a valid/ready channel. Once `cpu_valid` is raised, the request (`cpu_write`, `cpu_tag`) must stay stable until a cycle in which `cpu_ready` is high. That cycle completes the request, and the processor may then drop it or present a new one. A request that needs the bus raises `bus_req` with a command and a tag. The arbiter answers with `bus_gnt`, which means the transaction takes place on the bus in that same cycle. The arbiter grants only while `bus_req` is high, and never in a cycle that carries a snooped transaction. Transactions from other caches arrive on the snoop inputs, one per cycle. This controller's own transaction is never presented there.

A snooped read or read-exclusive that finds a Modified line raises `flush_valid` for one cycle. Memory and the requesting cache both take the data from that flush. When every tracked line is occupied and a miss arrives, a victim is taken from a rotating pointer. A Modified victim is first written back with its own bus transaction.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every tracked line is Invalid: no flush is produced, and the first request to any tag needs the bus.
- R2: A read to a Shared or Modified line, or a write to a Modified line, completes in the cycle it is presented: `cpu_ready` and `cpu_hit` are high and `bus_req` is low.
- R3: A read to an absent line raises `bus_req` with command 1 (read) and `cpu_tag`. `cpu_ready` stays low until the cycle of `bus_gnt` and is high in that cycle. The line becomes Shared.
- R4: A write to an absent or Shared line raises `bus_req` with command 2 (read-exclusive) and completes on grant. The line becomes Modified, so a following write completes without the bus.
- R5: A snooped read (`snp_cmd` 1) to a Modified line raises `flush_valid` with `flush_tag` = `snp_tag` in that cycle and leaves the line Shared: reads still hit, and a write needs command 2.
- R6: A snooped read-exclusive (`snp_cmd` 2) makes a Modified line Invalid with a flush, and a Shared line Invalid without one. The next read needs command 1.
- R7: The following have no effect on state or outputs: a snooped read to a Shared line, a snooped write-back (`snp_cmd` 3), and any snoop to a tag that is not held.
- R8: A miss with all lines occupied (no Invalid entry) replaces the entry named by a pointer. The pointer starts at entry 0 and advances by one, wrapping, on each replacement. A Modified victim first needs command 3 (write-back) with the victim's tag, and `cpu_ready` stays low in that grant cycle. A Shared victim is overwritten by the fill with no write-back. A new line fills the lowest Invalid entry.
- R9: When a snoop carries the same tag as the pending processor request in the same cycle, `cpu_ready` is low in that cycle. The request is evaluated again in the next cycle against the state the snoop left.
- R10: A waiting request is re-derived every cycle from the current state. For example, if a snoop downgrades a Modified victim to Shared, its write-back is dropped and the fill is requested instead.
- R11: `bus_req` is raised only while `cpu_valid` is high. While a request waits with no grant and no snoop, its command and tag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_tag | input | TAG_W | Line tag of the request |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Request completed without the bus |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | 1 read, 2 read-exclusive, 3 write-back |
| bus_tag | output | TAG_W | Tag of the bus transaction |
| bus_gnt | input | 1 | Transaction takes place this cycle |
| snp_valid | input | 1 | Another cache's transaction on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding |
| snp_tag | input | TAG_W | Snooped tag |
| flush_valid | output | 1 | Dirty data must be flushed this cycle |
| flush_tag | output | TAG_W | Tag being flushed |

## Verification
A processor request and a snooped transaction can fall in the same cycle. When their tags match, the snoop has to win and the request must retry. The bench provokes this directly: it holds reads and writes on Shared and Modified lines while snooped reads and read-exclusives to the same tag arrive. It also snoops a Modified victim while that victim's write-back waits for a grant. A behavioural reference model judges every cycle. The model applies the snoop first and re-derives the request from the resulting state. In a long mixed phase, snoops, grants and requests collide freely over a small tag set.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/msi_tag_match.sv
module msi_tag_match #(
  parameter int LINES = 4,
  parameter int TAG_W = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES-1:0]            occ,
  input  logic [LINES-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]            key,
  output logic                        hit,
  output logic [IDX_W-1:0]            idx
);
  logic [LINES-1:0] match;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = occ[g] && (tags[g] == key);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/msi_alloc.sv
module msi_alloc #(
  parameter int LINES = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] occ,
  input  logic             advance,
  output logic             free_any,
  output logic [IDX_W-1:0] free_idx,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (advance) ptr_q <= (ptr_q == IDX_W'(LINES - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign victim_idx = ptr_q;
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic             cpu_write,
  input  logic [TAG_W-1:0] cpu_tag,
  output logic             cpu_ready,
  output logic             cpu_hit,
  output logic             bus_req,
  output logic [1:0]       bus_cmd,
  output logic [TAG_W-1:0] bus_tag,
  input  logic             bus_gnt,
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             flush_valid,
  output logic [TAG_W-1:0] flush_tag
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  line_st_t [LINES-1:0]            st_q;
  logic     [LINES-1:0][TAG_W-1:0] tag_q;
  logic     [LINES-1:0]            occ;

  for (genvar g = 0; g < LINES; g++) begin : g_occ
    assign occ[g] = (st_q[g] != ST_I);
  end

  logic             c_hit, s_hit, free_any, advance;
  logic [IDX_W-1:0] c_idx, s_idx, free_idx, victim_idx, target;

  msi_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) i_cpu_match (
    .occ(occ), .tags(tag_q), .key(cpu_tag), .hit(c_hit), .idx(c_idx)
  );

  msi_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) i_snp_match (
    .occ(occ), .tags(tag_q), .key(snp_tag), .hit(s_hit), .idx(s_idx)
  );

  msi_alloc #(.LINES(LINES)) i_alloc (
    .clk(clk), .rst_n(rst_n), .occ(occ), .advance(advance),
    .free_any(free_any), .free_idx(free_idx), .victim_idx(victim_idx)
  );

  line_st_t c_state;
  logic     no_bus, collide, full_miss, victim_dirty;
  bus_cmd_t cmd;

  always_comb begin
    c_state      = c_hit ? st_q[c_idx] : ST_I;
    no_bus       = cpu_valid && c_hit && (!cpu_write || c_state == ST_M);
    collide      = cpu_valid && snp_valid && (snp_tag == cpu_tag);
    full_miss    = !c_hit && !free_any;
    victim_dirty = full_miss && (st_q[victim_idx] == ST_M);
    target       = c_hit ? c_idx : (free_any ? free_idx : victim_idx);
    cmd          = CMD_NONE;
    bus_tag      = cpu_tag;
    if (cpu_valid && !no_bus) begin
      if (victim_dirty) begin
        cmd     = CMD_WB;
        bus_tag = tag_q[victim_idx];
      end else begin
        cmd = cpu_write ? CMD_RDX : CMD_RD;
      end
    end
  end

  assign bus_req   = (cmd != CMD_NONE);
  assign bus_cmd   = cmd;
  assign cpu_ready = cpu_valid && !collide &&
                     (no_bus || (bus_gnt && bus_req && cmd != CMD_WB));
  assign cpu_hit   = cpu_ready && no_bus;
  assign advance   = bus_gnt && bus_req && (cmd == CMD_WB || full_miss);

  assign flush_valid = snp_valid && s_hit && (st_q[s_idx] == ST_M) &&
                       (snp_cmd == CMD_RD || snp_cmd == CMD_RDX);
  assign flush_tag   = snp_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else if (snp_valid && s_hit) begin
      if (snp_cmd == CMD_RD && st_q[s_idx] == ST_M) st_q[s_idx] <= ST_S;
      else if (snp_cmd == CMD_RDX) st_q[s_idx] <= ST_I;
    end else if (bus_gnt && bus_req) begin
      case (cmd)
        CMD_WB:  st_q[victim_idx] <= ST_I;
        CMD_RD: begin
          st_q[target]  <= ST_S;
          tag_q[target] <= cpu_tag;
        end
        CMD_RDX: begin
          st_q[target]  <= ST_M;
          tag_q[target] <= cpu_tag;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_valid,
  input logic [TAG_W-1:0] cpu_tag,
  input logic             cpu_ready,
  input logic             cpu_hit,
  input logic             bus_req,
  input logic [1:0]       bus_cmd,
  input logic [TAG_W-1:0] bus_tag,
  input logic             bus_gnt,
  input logic             snp_valid,
  input logic [1:0]       snp_cmd,
  input logic [TAG_W-1:0] snp_tag,
  input logic             flush_valid,
  input logic [TAG_W-1:0] flush_tag
);
  a_r5_flush_only_on_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2) && flush_tag == snp_tag);

  a_r2_hit_without_bus: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> cpu_ready && !bus_req);

  a_r8_wb_holds_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_cmd == 2'd3) |-> !cpu_ready);

  a_r9_collision_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && snp_valid && snp_tag == cpu_tag) |-> !cpu_ready);

  a_r11_req_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || cpu_ready) |-> cpu_valid);

  a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=>
      (!cpu_valid || (bus_req && $stable(bus_cmd) && $stable(bus_tag))));

  a_r3_ready_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_hit) |-> bus_gnt && bus_cmd != 2'd3);
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.TAG_W(TAG_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_tag(cpu_tag),
  .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .bus_req(bus_req), .bus_cmd(bus_cmd),
  .bus_tag(bus_tag), .bus_gnt(bus_gnt), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_tag(snp_tag), .flush_valid(flush_valid), .flush_tag(flush_tag)
);

// File: tb/test_msi_snoop_ctrl.sv
module test_msi_snoop_ctrl;
  localparam int LINES = 4;
  localparam int TAG_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 0, cpu_write = 0, bus_gnt = 0, snp_valid = 0;
  logic [TAG_W-1:0] cpu_tag = '0, snp_tag = '0;
  logic [1:0] snp_cmd = '0;
  logic cpu_ready, cpu_hit, bus_req, flush_valid;
  logic [1:0] bus_cmd;
  logic [TAG_W-1:0] bus_tag, flush_tag;

  always #5 clk = ~clk;

  msi_snoop_ctrl #(.LINES(LINES), .TAG_W(TAG_W)) i_msi_snoop_ctrl (.*);

  int tests = 0, fails = 0;
  string cur_req = "R1";

  // reference model: 0 Invalid, 1 Shared, 2 Modified
  int mst[LINES];
  logic [TAG_W-1:0] mtg[LINES];
  int mptr;
  logic e_ready, e_hit, e_req, e_flush;
  int e_cmd, e_target;
  logic [TAG_W-1:0] e_tag;
  bit e_full;

  function automatic int find(logic [TAG_W-1:0] t);
    for (int i = 0; i < LINES; i++) if (mst[i] != 0 && mtg[i] == t) return i;
    return -1;
  endfunction

  task automatic model_eval();
    int h, f, sh;
    bit nb;
    h = find(cpu_tag);
    f = -1;
    for (int i = LINES - 1; i >= 0; i--) if (mst[i] == 0) f = i;
    nb = cpu_valid && h >= 0 && (!cpu_write || mst[h] == 2);
    e_full = (h < 0 && f < 0);
    e_target = (h >= 0) ? h : ((f >= 0) ? f : mptr);
    e_cmd = 0;
    e_tag = cpu_tag;
    if (cpu_valid && !nb) begin
      if (e_full && mst[mptr] == 2) begin e_cmd = 3; e_tag = mtg[mptr]; end
      else e_cmd = cpu_write ? 2 : 1;
    end
    e_req = (e_cmd != 0);
    e_ready = cpu_valid && !(snp_valid && snp_tag == cpu_tag) &&
              (nb || (bus_gnt && e_cmd != 0 && e_cmd != 3));
    e_hit = e_ready && nb;
    sh = find(snp_tag);
    e_flush = snp_valid && sh >= 0 && mst[sh] == 2 && (snp_cmd == 1 || snp_cmd == 2);
  endtask

  task automatic model_update();
    int sh;
    if (snp_valid) begin
      sh = find(snp_tag);
      if (sh >= 0) begin
        if (snp_cmd == 1 && mst[sh] == 2) mst[sh] = 1;
        else if (snp_cmd == 2) mst[sh] = 0;
      end
    end else if (bus_gnt && e_req) begin
      if (e_cmd == 3) begin
        mst[mptr] = 0;
        mptr = (mptr + 1) % LINES;
      end else begin
        if (e_full) mptr = (mptr + 1) % LINES;
        mst[e_target] = e_cmd;
        mtg[e_target] = cpu_tag;
      end
    end
  endtask

  task automatic chk(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  // one cycle: inputs after negedge, grant after request settles, compare, update at edge
  task automatic cycle(bit v, bit w, logic [TAG_W-1:0] t,
                       bit sv, logic [1:0] sc, logic [TAG_W-1:0] st, bit g);
    @(negedge clk);
    cpu_valid = v; cpu_write = w; cpu_tag = t;
    snp_valid = sv; snp_cmd = sc; snp_tag = st; bus_gnt = 1'b0;
    #1;
    model_eval();
    bus_gnt = g && e_req && !sv;
    #1;
    model_eval();
    chk("cpu_ready", int'(cpu_ready), int'(e_ready));
    chk("cpu_hit", int'(cpu_hit), int'(e_hit));
    chk("bus_req", int'(bus_req), int'(e_req));
    if (e_req) begin
      chk("bus_cmd", int'(bus_cmd), e_cmd);
      chk("bus_tag", int'(bus_tag), int'(e_tag));
    end
    chk("flush_valid", int'(flush_valid), int'(e_flush));
    if (e_flush) chk("flush_tag", int'(flush_tag), int'(snp_tag));
    @(posedge clk);
    model_update();
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0, 0, 0);
  endtask

  // processor request, grant withheld for 'wait_n' requesting cycles
  task automatic op(bit w, logic [TAG_W-1:0] t, int wait_n);
    int n = 0;
    bit done = 0;
    while (!done && n < 40) begin
      cycle(1, w, t, 0, 0, 0, n >= wait_n);
      done = e_ready;
      n++;
    end
    chk("completed", int'(done), 1);
  endtask

  task automatic snoop(logic [1:0] c, logic [TAG_W-1:0] t);
    cycle(0, 0, 0, 1, c, t, 0);
  endtask

  // expect the next request to be completed locally (1) or through the bus with command c
  task automatic probe(bit w, logic [TAG_W-1:0] t, int exp_cmd);
    cycle(1, w, t, 0, 0, 0, 0);
    chk("probe_cmd", e_req ? int'(bus_cmd) : 0, exp_cmd);
    if (exp_cmd == 0) chk("probe_hit", int'(cpu_hit), 1);
    op(w, t, 0);
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin mst[i] = 0; mtg[i] = '0; end
    mptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cur_req = "R1";
    idle();
    snoop(1, 8'h10);
    probe(0, 8'h10, 1);            // first read needs the bus, fills Shared

    cur_req = "R3";
    op(0, 8'h11, 3);               // ready withheld three cycles
    cur_req = "R2";
    probe(0, 8'h10, 0);
    cur_req = "R4";
    probe(1, 8'h10, 2);            // Shared -> Modified
    probe(1, 8'h10, 0);
    cur_req = "R2";
    probe(0, 8'h10, 0);

    cur_req = "R5";
    snoop(1, 8'h10);               // flush, now Shared
    probe(0, 8'h10, 0);
    probe(1, 8'h10, 2);

    cur_req = "R6";
    snoop(2, 8'h10);               // Modified -> Invalid with flush
    probe(0, 8'h10, 1);
    snoop(2, 8'h10);               // Shared -> Invalid, no flush
    probe(0, 8'h10, 1);

    cur_req = "R7";
    snoop(1, 8'h10);
    snoop(3, 8'h10);
    snoop(2, 8'h77);
    probe(0, 8'h10, 0);

    cur_req = "R8";
    op(1, 8'h20, 1);
    op(0, 8'h21, 0);               // table now 10 S,11 S,20 M,21 S
    probe(0, 8'h30, 1);            // Shared victim entry 0
    probe(0, 8'h31, 1);            // Shared victim entry 1
    probe(0, 8'h32, 3);            // Modified victim entry 2 written back first
    probe(0, 8'h11, 1);            // entry 3 replaced

    cur_req = "R9";
    op(1, 8'h30, 0);               // 30 Modified
    cycle(1, 0, 8'h30, 1, 1, 8'h30, 0);
    op(0, 8'h30, 0);
    cycle(1, 1, 8'h30, 1, 2, 8'h30, 0);
    probe(1, 8'h30, 2);

    cur_req = "R10";
    op(1, 8'h31, 0);
    op(1, 8'h32, 0);
    op(1, 8'h11, 0);               // all Modified; victim pointer points at a dirty entry
    cycle(1, 0, 8'h40, 0, 0, 0, 0);
    snoop(1, bus_tag);             // downgrade the victim while its write-back waits
    cycle(1, 0, 8'h40, 0, 0, 0, 0);
    chk("wb_dropped", int'(bus_cmd), 1);
    op(0, 8'h40, 0);

    cur_req = "R11";
    for (int k = 0; k < 3000; k++) begin
      bit w = $urandom_range(0, 1);
      logic [TAG_W-1:0] t = 8'h50 + 8'($urandom_range(0, 6));
      int guard = 0;
      bit done = 0;
      while (!done && guard < 60) begin
        bit sv = ($urandom_range(0, 3) == 0);
        logic [TAG_W-1:0] st2 = ($urandom_range(0, 2) == 0) ? t : 8'h50 + 8'($urandom_range(0, 6));
        cycle(1, w, t, sv, 2'($urandom_range(1, 3)), st2, $urandom_range(0, 1) == 1);
        done = e_ready;
        guard++;
      end
      chk("random_done", int'(done), 1);
      if ($urandom_range(0, 3) == 0) idle();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule